// File: doc/BRIEF.md
# I2C Bus Minimum-Time and Timeout Timer

This block is a 10-bit timer that sits beside a bit-level I2C engine. It gives the engine two things. The first is a minimum-time flag that tells the engine when an SCL high or low phase has lasted long enough. The second is an overflow pulse that shows the bus has hung in the middle of a frame. The timer advances only on a machine-cycle enable, which is high once every twelve oscillator clocks. A two-bit speed code sets both the minimum phase time and the timeout length.

Three interface enables (slave enable, master request, master active) and a run bit select one of four modes:
- Off: the timer is held at zero.
- Free: the timer is a free-running time base.
- Low-only: only the low three bits count, for minimum-time generation, and no timeout can occur.
- Bus: the full timer counts, and every SCL transition, start condition and stop condition clears it.

Each timeout sets a sticky interrupt flag. Software clears that flag with a dedicated clear pulse.

The engine supplies the SCL edge pulses and the start and stop detect pulses. The timer does not generate the waveform and does not shift data.

Top module: `i2c_mintime_timer`

## Requirements
- R1: With all three interface enables low and run low (off mode), the count is held at zero, and `min_reached`, `tmo_pulse` and `tmo_irq` never become set. This is the state after reset.
- R2: With all enables low and run high (free mode), all 10 bits count one step per enabled cycle. `tmo_pulse` fires every 1024 enabled cycles. SCL, start and stop pulses are ignored.
- R3: With any enable high and run low (low-only mode), the low 3 bits count and raise `min_reached`. The upper 7 bits stay frozen, and `tmo_pulse` never fires.
- R4: With any enable high and run high (bus mode), an `scl_edge`, `start_det` or `stop_det` pulse clears the timer. A clear loads the low 3 bits with 8 minus the minimum count, and loads the upper bits with zero.
- R5: The speed code `spd_sel` maps to a minimum count and a timeout (enabled cycles from a clear) as follows: 2'b10 gives 7 and 1023, 2'b01 gives 6 and 1022, 2'b00 gives 5 and 1021, and 2'b11 gives 4 and 1020.
- R6: In the bus modes, `min_reached` rises on the clock edge where the low field wraps from 7 to 0. It stays high until the next clear, and it falls on the same edge that applies the clear.
- R7: `tmo_pulse` is high for exactly one cycle, on the edge where the 10-bit count wraps from 1023 to 0.
- R8: `tmo_irq` is set by each timeout and stays set until an `irq_clr` pulse. When `irq_clr` coincides with a timeout, the clear wins.
- R9: The count changes only in cycles where `mc_en` is high. A clear event takes priority over counting in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mc_en | input | 1 | Machine-cycle enable (one cycle in twelve) |
| slv_en | input | 1 | Interface enable: slave |
| mst_req | input | 1 | Interface enable: master request |
| mst_act | input | 1 | Interface enable: master active |
| run | input | 1 | Run control |
| spd_sel | input | 2 | Speed code (see R5) |
| scl_edge | input | 1 | Pulse on any SCL transition |
| start_det | input | 1 | Pulse on a start condition |
| stop_det | input | 1 | Pulse on a stop condition |
| irq_clr | input | 1 | Clears the sticky timeout flag |
| min_reached | output | 1 | Minimum phase time has elapsed since the last clear |
| tmo_pulse | output | 1 | One-cycle timeout (overflow) pulse |
| tmo_irq | output | 1 | Sticky timeout interrupt flag |

## Verification
The assertions assume that `spd_sel` is constant for as long as a clear can load the timer. They also assume that `irq_clr` and the event pulses are synchronous single-clock signals.

The stimulus keeps within these assumptions:
- It changes the speed code only before issuing a clear.
- It drives every input at the falling clock edge.
- It enters free mode only from off mode, so that the free-running count starts at zero and the overflow cycle is known exactly.

// File: rtl/i2c_tmr_pkg.sv
package i2c_tmr_pkg;

   typedef enum logic [1:0] {
      TM_OFF     = 2'b00,
      TM_FREE    = 2'b01,
      TM_LOWONLY = 2'b10,
      TM_BUS     = 2'b11
   } tmr_mode_e;

   // Minimum phase count for a speed code: the floor plus a rank that
   // rotates the code by one so that the all-ones code is the shortest.
   function automatic int unsigned min_phase_cycles(input int unsigned code,
                                                    input int unsigned spd_w,
                                                    input int unsigned floor_v);
      return floor_v + ((code + 1) % (1 << spd_w));
   endfunction

endpackage

// File: rtl/i2c_tmr_mode.sv
module i2c_tmr_mode
   import i2c_tmr_pkg::*;
#(
   parameter int N_EN = 3
) (
   input  logic [N_EN-1:0] en_vec,
   input  logic            run,
   input  logic            scl_edge,
   input  logic            start_det,
   input  logic            stop_det,
   output tmr_mode_e       mode,
   output logic            hold_zero,
   output logic            bus_on,
   output logic            carry_en,
   output logic            clr_evt
);

   if (N_EN < 1) begin : g_bad_en
      $error("i2c_tmr_mode: N_EN must be at least 1");
   end

   logic any_en;

   always_comb begin
      any_en    = |en_vec;
      mode      = tmr_mode_e'({any_en, run});
      hold_zero = (mode == TM_OFF);
      bus_on    = any_en;
      carry_en  = run;
      clr_evt   = any_en & (scl_edge | start_det | stop_det);
   end

endmodule

// File: rtl/i2c_tmr_speed.sv
module i2c_tmr_speed
   import i2c_tmr_pkg::*;
#(
   parameter int LOW_W     = 3,
   parameter int SPD_W     = 2,
   parameter int MIN_FLOOR = 4
) (
   input  logic [SPD_W-1:0] spd_sel,
   output logic [LOW_W-1:0] load_low
);

   localparam int N_CODES  = 1 << SPD_W;
   localparam int LOW_SPAN = 1 << LOW_W;

   if (MIN_FLOOR < 1 || (MIN_FLOOR + N_CODES - 1) > LOW_SPAN) begin : g_bad_range
      $error("i2c_tmr_speed: minimum counts do not fit the low field");
   end

   logic [LOW_W-1:0] preload_tbl [N_CODES];

   for (genvar c = 0; c < N_CODES; c++) begin : g_code
      localparam int unsigned MC = min_phase_cycles(c, SPD_W, MIN_FLOOR);
      assign preload_tbl[c] = LOW_W'(LOW_SPAN - int'(MC));
   end

   assign load_low = preload_tbl[spd_sel];

endmodule

// File: rtl/i2c_tmr_count.sv
module i2c_tmr_count #(
   parameter int CNT_W = 10,
   parameter int LOW_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hold_zero,
   input  logic             load,
   input  logic             step,
   input  logic             carry_en,
   input  logic [LOW_W-1:0] load_low,
   output logic [CNT_W-1:0] cnt,
   output logic             low_wrap,
   output logic             full_wrap
);

   localparam int HI_W = CNT_W - LOW_W;

   if (LOW_W < 1 || HI_W < 1) begin : g_bad_split
      $error("i2c_tmr_count: need LOW_W >= 1 and CNT_W > LOW_W");
   end

   logic [LOW_W-1:0] lo_q;
   logic [HI_W-1:0]  hi_q;

   assign low_wrap  = &lo_q;
   assign full_wrap = low_wrap & (&hi_q);
   assign cnt       = {hi_q, lo_q};

   // Low field: runs in every counting mode.
   always_ff @(posedge clk) begin
      if (!rst_n || hold_zero) begin
         lo_q <= '0;
      end else if (load) begin
         lo_q <= load_low;
      end else if (step) begin
         lo_q <= lo_q + 1'b1;
      end
   end

   // High field: takes the carry only while the run control is on.
   always_ff @(posedge clk) begin
      if (!rst_n || hold_zero || load) begin
         hi_q <= '0;
      end else if (step && carry_en && low_wrap) begin
         hi_q <= hi_q + 1'b1;
      end
   end

endmodule

// File: rtl/i2c_tmr_flags.sv
module i2c_tmr_flags (
   input  logic clk,
   input  logic rst_n,
   input  logic bus_on,
   input  logic clr_evt,
   input  logic step,
   input  logic carry_en,
   input  logic low_wrap,
   input  logic full_wrap,
   input  logic irq_clr,
   output logic min_reached,
   output logic tmo_pulse,
   output logic tmo_irq
);

   logic adv, set_min, ovf;

   always_comb begin
      adv     = step & ~clr_evt;
      set_min = bus_on & adv & low_wrap;
      ovf     = carry_en & adv & full_wrap;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !bus_on || clr_evt) begin
         min_reached <= 1'b0;
      end else if (set_min) begin
         min_reached <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tmo_pulse <= 1'b0;
      end else begin
         tmo_pulse <= ovf;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || irq_clr) begin
         tmo_irq <= 1'b0;
      end else if (ovf) begin
         tmo_irq <= 1'b1;
      end
   end

endmodule

// File: rtl/i2c_mintime_timer.sv
module i2c_mintime_timer
   import i2c_tmr_pkg::*;
#(
   parameter int CNT_W     = 10,
   parameter int LOW_W     = 3,
   parameter int SPD_W     = 2,
   parameter int MIN_FLOOR = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mc_en,
   input  logic             slv_en,
   input  logic             mst_req,
   input  logic             mst_act,
   input  logic             run,
   input  logic [SPD_W-1:0] spd_sel,
   input  logic             scl_edge,
   input  logic             start_det,
   input  logic             stop_det,
   input  logic             irq_clr,
   output logic             min_reached,
   output logic             tmo_pulse,
   output logic             tmo_irq
);

   localparam int N_EN = 3;

   tmr_mode_e        mode;
   logic             hold_zero, bus_on, carry_en, clr_evt;
   logic [LOW_W-1:0] load_low;
   logic [CNT_W-1:0] cnt_q;
   logic             low_wrap, full_wrap;

   i2c_tmr_mode #(.N_EN(N_EN)) u_mode (
      .en_vec    ({mst_act, mst_req, slv_en}),
      .run       (run),
      .scl_edge  (scl_edge),
      .start_det (start_det),
      .stop_det  (stop_det),
      .mode      (mode),
      .hold_zero (hold_zero),
      .bus_on    (bus_on),
      .carry_en  (carry_en),
      .clr_evt   (clr_evt)
   );

   i2c_tmr_speed #(.LOW_W(LOW_W), .SPD_W(SPD_W), .MIN_FLOOR(MIN_FLOOR)) u_speed (
      .spd_sel  (spd_sel),
      .load_low (load_low)
   );

   i2c_tmr_count #(.CNT_W(CNT_W), .LOW_W(LOW_W)) u_count (
      .clk       (clk),
      .rst_n     (rst_n),
      .hold_zero (hold_zero),
      .load      (clr_evt),
      .step      (mc_en),
      .carry_en  (carry_en),
      .load_low  (load_low),
      .cnt       (cnt_q),
      .low_wrap  (low_wrap),
      .full_wrap (full_wrap)
   );

   i2c_tmr_flags u_flags (
      .clk         (clk),
      .rst_n       (rst_n),
      .bus_on      (bus_on),
      .clr_evt     (clr_evt),
      .step        (mc_en),
      .carry_en    (carry_en),
      .low_wrap    (low_wrap),
      .full_wrap   (full_wrap),
      .irq_clr     (irq_clr),
      .min_reached (min_reached),
      .tmo_pulse   (tmo_pulse),
      .tmo_irq     (tmo_irq)
   );

endmodule

// File: rtl/i2c_tmr_chk.sv
module i2c_tmr_chk #(
   parameter int CNT_W     = 10,
   parameter int LOW_W     = 3,
   parameter int SPD_W     = 2,
   parameter int MIN_FLOOR = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             any_en,
   input logic             run,
   input logic             mc_en,
   input logic             clr_any,
   input logic [SPD_W-1:0] spd_sel,
   input logic             irq_clr,
   input logic [CNT_W-1:0] cnt,
   input logic             min_reached,
   input logic             tmo_pulse,
   input logic             tmo_irq
);

   if (SPD_W != 2) begin : g_chk_spd
      $error("i2c_tmr_chk: written for a two-bit speed code");
   end

   function automatic logic [LOW_W-1:0] exp_preload(input logic [SPD_W-1:0] code);
      int m;
      case (code)
         2'b10:   m = MIN_FLOOR + 3;
         2'b01:   m = MIN_FLOOR + 2;
         2'b00:   m = MIN_FLOOR + 1;
         default: m = MIN_FLOOR;
      endcase
      return LOW_W'((1 << LOW_W) - m);
   endfunction

   a_r1_off_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      (!any_en && !run) |=> (cnt == '0 && !min_reached && !tmo_pulse));

   a_r2_free_step: assert property (@(posedge clk) disable iff (!rst_n)
      (!any_en && run && mc_en) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

   a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      (any_en && !run) |=> !tmo_pulse);

   a_r3_upper_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (any_en && !run && !clr_any) |=> $stable(cnt[CNT_W-1:LOW_W]));

   a_r4_clear_preload: assert property (@(posedge clk) disable iff (!rst_n)
      (any_en && clr_any) |=> (cnt[LOW_W-1:0] == exp_preload($past(spd_sel)) &&
                               cnt[CNT_W-1:LOW_W] == '0 && !min_reached));

   a_r6_min_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (min_reached && any_en && !clr_any) |=> min_reached);

   a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      tmo_pulse |=> !tmo_pulse);

   a_r7_pulse_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
      tmo_pulse |-> (cnt == '0));

   a_r8_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
      irq_clr |=> !tmo_irq);

   a_r8_pulse_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (tmo_pulse && !$past(irq_clr)) |-> tmo_irq);

   a_r9_no_step: assert property (@(posedge clk) disable iff (!rst_n)
      (!mc_en && !clr_any && (any_en || run)) |=> $stable(cnt));

endmodule

bind i2c_mintime_timer i2c_tmr_chk #(
   .CNT_W(CNT_W), .LOW_W(LOW_W), .SPD_W(SPD_W), .MIN_FLOOR(MIN_FLOOR)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .any_en      (slv_en | mst_req | mst_act),
   .run         (run),
   .mc_en       (mc_en),
   .clr_any     ((slv_en | mst_req | mst_act) & (scl_edge | start_det | stop_det)),
   .spd_sel     (spd_sel),
   .irq_clr     (irq_clr),
   .cnt         (cnt_q),
   .min_reached (min_reached),
   .tmo_pulse   (tmo_pulse),
   .tmo_irq     (tmo_irq)
);

// File: tb/i2c_mintime_timer_tb.sv
module i2c_mintime_timer_tb;

   localparam int CLK_PERIOD = 10;
   localparam int LIMIT      = 5000;

   // speed code, min count, timeout length (R5)
   localparam int VEC [4][3] = '{
      '{2, 7, 1023},
      '{1, 6, 1022},
      '{0, 5, 1021},
      '{3, 4, 1020}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mc_en = 1'b0;
   logic       slv_en = 1'b0, mst_req = 1'b0, mst_act = 1'b0, run = 1'b0;
   logic [1:0] spd_sel = 2'b00;
   logic       scl_edge = 1'b0, start_det = 1'b0, stop_det = 1'b0, irq_clr = 1'b0;
   logic       min_reached, tmo_pulse, tmo_irq;

   int n_chk = 0;
   int n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   i2c_mintime_timer u_dut (
      .clk(clk), .rst_n(rst_n), .mc_en(mc_en),
      .slv_en(slv_en), .mst_req(mst_req), .mst_act(mst_act), .run(run),
      .spd_sel(spd_sel), .scl_edge(scl_edge), .start_det(start_det),
      .stop_det(stop_det), .irq_clr(irq_clr),
      .min_reached(min_reached), .tmo_pulse(tmo_pulse), .tmo_irq(tmo_irq)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   // which: 0 scl, 1 start, 2 stop
   task automatic pulse_evt(input int which);
      scl_edge  = (which == 0);
      start_det = (which == 1);
      stop_det  = (which == 2);
      tick();
      scl_edge = 1'b0; start_det = 1'b0; stop_det = 1'b0;
   endtask

   task automatic run_until_min(output int n);
      n = 0;
      while (!min_reached && n < LIMIT) begin tick(); n++; end
   endtask

   task automatic run_until_pulse(inout int n);
      while (!tmo_pulse && n < LIMIT) begin tick(); n++; end
   endtask

   task automatic go_off();
      slv_en = 1'b0; mst_req = 1'b0; mst_act = 1'b0; run = 1'b0;
      tick();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      int n;
      int seen;
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      // R1 reset state
      chk("R1 reset min", min_reached, 0);
      chk("R1 reset pulse", tmo_pulse, 0);
      chk("R1 reset irq", tmo_irq, 0);

      // R1 off mode stays quiet with enable running
      mc_en = 1'b1;
      seen = 0;
      for (int i = 0; i < 1100; i++) begin
         scl_edge = (i % 7 == 0);
         tick();
         if (tmo_pulse || min_reached || tmo_irq) seen++;
      end
      scl_edge = 1'b0;
      chk("R1 off no activity", seen, 0);

      // R2 free mode from a zero count, bus events ignored
      run = 1'b1;
      n = 0;
      while (!tmo_pulse && n < LIMIT) begin
         scl_edge = (n == 100);
         start_det = (n == 300);
         tick();
         n++;
      end
      scl_edge = 1'b0; start_det = 1'b0;
      chk("R2 free overflow period", n, 1024);
      chk("R8 irq set by overflow", tmo_irq, 1);
      chk("R6 no min flag in free mode", min_reached, 0);

      // R8 software clear, R7 single pulse
      irq_clr = 1'b1;
      tick();
      irq_clr = 1'b0;
      chk("R8 irq cleared", tmo_irq, 0);
      chk("R7 pulse one cycle", tmo_pulse, 0);
      repeat (1022) tick();
      irq_clr = 1'b1;
      tick();
      irq_clr = 1'b0;
      chk("R2 second period pulse", tmo_pulse, 1);
      chk("R8 clear wins over set", tmo_irq, 0);
      tick();
      chk("R8 irq stays clear", tmo_irq, 0);
      go_off();
      chk("R1 off after free", min_reached, 0);

      // Vector table: bus mode, speed codes (R5, R6, R7, R8)
      for (int v = 0; v < 4; v++) begin
         slv_en = (v % 2 == 0); mst_act = (v % 2 == 1); run = 1'b1;
         spd_sel = 2'(VEC[v][0]);
         irq_clr = 1'b1;
         pulse_evt(0);
         irq_clr = 1'b0;
         chk("R6 flag low after clear", min_reached, 0);
         run_until_min(n);
         chk($sformatf("R5 min count code %0d", VEC[v][0]), n, VEC[v][1]);
         repeat (3) tick();
         n += 3;
         chk("R6 min flag sticky", min_reached, 1);
         run_until_pulse(n);
         chk($sformatf("R5 timeout code %0d", VEC[v][0]), n, VEC[v][2]);
         chk("R8 irq after timeout", tmo_irq, 1);
         chk("R6 flag held at timeout", min_reached, 1);
      end
      slv_en = 1'b0; mst_act = 1'b0;
      go_off();
      chk("R1 leaving bus mode drops flag", min_reached, 0);

      // R3 low-only mode
      irq_clr = 1'b1; tick(); irq_clr = 1'b0;
      mst_req = 1'b1; run = 1'b0; spd_sel = 2'b00;
      pulse_evt(0);
      run_until_min(n);
      chk("R3 low-only min count", n, 5);
      seen = 0;
      for (int i = 0; i < 1100; i++) begin
         tick();
         if (tmo_pulse) seen++;
         if (!min_reached) seen++;
      end
      chk("R3 no timeout, flag held", seen, 0);
      chk("R3 no irq", tmo_irq, 0);
      pulse_evt(2);
      chk("R6 stop clears flag", min_reached, 0);
      run_until_min(n);
      chk("R4 stop restarts min time", n, 5);
      mst_req = 1'b0;
      go_off();

      // R4 start/stop clears in bus mode
      slv_en = 1'b1; run = 1'b1; spd_sel = 2'b10;
      pulse_evt(0);
      repeat (4) tick();
      pulse_evt(1);
      run_until_min(n);
      chk("R4 start clears", n, 7);
      repeat (2) tick();
      pulse_evt(2);
      chk("R4 stop drops flag", min_reached, 0);
      run_until_min(n);
      chk("R4 stop clears", n, 7);

      // R4 frequent SCL edges keep the timer from timing out
      spd_sel = 2'b11;
      seen = 0;
      for (int i = 0; i < 3000; i++) begin
         scl_edge = (i % 3 == 0);
         tick();
         if (tmo_pulse) seen++;
         if (i > 2 && min_reached) seen++;
      end
      scl_edge = 1'b0;
      chk("R4 scl edges hold off timeout", seen, 0);

      // R9 no counting without the enable
      spd_sel = 2'b01;
      pulse_evt(0);
      mc_en = 1'b0;
      repeat (50) tick();
      chk("R9 stalled without enable", min_reached, 0);
      mc_en = 1'b1;
      run_until_min(n);
      chk("R9 resumes count", n, 6);

      // R9 clear overrides counting
      scl_edge = 1'b1;
      seen = 0;
      for (int i = 0; i < 20; i++) begin
         tick();
         if (min_reached) seen++;
      end
      scl_edge = 1'b0;
      chk("R9 clear beats count", seen, 0);
      run_until_min(n);
      chk("R9 count after held clear", n, 6);

      go_off();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule